// File: doc/BRIEF.md
# PRBS7 Receive Alignment Checker

This block sits at the receive end of a parallel data link while the sender outputs a 7-bit pseudo-random test sequence. The sender copies each sequence bit onto every line of the bus. The checker takes one word per enabled sample clock and uses line 0 as the sequence bit.

The sequence has period 127 and follows the recurrence b[n] = b[n-7] XOR b[n-6], which is the polynomial x^7 + x^6 + 1. The sender's starting point is unknown. In search the checker therefore shifts received bits into a 7-bit history, predicts each next bit from that history, and declares lock after a run of correct predictions. Once locked, the history runs from its own feedback. Every later disagreement with the line is then a bit error.

A separate flag reports when the lines of one word do not all carry the same value, which points to a wiring or timing fault on some lane. A sliding window of recent errors returns the checker to search when the link is clearly broken.

Top module: `prbs7_align_chk`

## Requirements
- R1: From reset, a clean sequence starting at any of its 127 phases raises `locked` after exactly 23 enabled samples (7 to fill the history, then 16 correct predictions), and not after 22.
- R2: A history of all zeros never starts a lock run, so a stream of zeros leaves `locked` low for good.
- R3: `line_fault` is high in the cycle after an enabled sample whose lines are not all equal, and low after one whose lines agree. Only line 0 feeds the sequence comparison, so a disagreeing line other than 0 does not count as a bit error.
- R4: While locked, each sample whose line 0 differs from the predicted bit raises `err_count` by one, and fewer than 8 such errors within any 32 consecutive samples keep `locked` high.
- R5: While locked, the 8th error inside any 32 consecutive samples drops `locked` at that sample's clock edge. Eight errors spread over 36 samples do not drop it.
- R6: While searching, prediction misses never change `err_count`.
- R7: `err_count` saturates at its all-ones value.
- R8: With `en` low, `locked`, `err_count` and `line_fault` hold their values whatever the bus carries.
- R9: Reset clears `locked`, `err_count` and `line_fault`.
- R10: After a drop, the checker locks again after the same 23 clean samples as from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Sample valid; state advances only when high |
| rx_word | input | LINES | Received parallel word, one sequence bit copied onto every line |
| locked | output | 1 | Local sequence aligned to the incoming stream |
| line_fault | output | 1 | Lines of the last enabled sample disagreed |
| err_count | output | CNT_W | Saturating count of bit errors seen while locked |

## Verification
The assertions assume that reset is applied before the first useful edge and that `en` marks the only samples that count. The bench drives reset at the start, holds `en` low only in a window where it also scrambles the bus, and builds every word from an independently generated copy of the sequence. Bit errors are injected by inverting all lines, and lane faults by flipping a single line other than 0. This keeps the error count and the line-agreement flag as two separate observations.

// File: rtl/prbs7_align_chk.sv
module prbs7_align_chk #(
  parameter int LINES     = 12,
  parameter int LOCK_RUN  = 16,
  parameter int WIN       = 32,
  parameter int DROP_ERRS = 8,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LINES-1:0] rx_word,
  output logic             locked,
  output logic             line_fault,
  output logic [CNT_W-1:0] err_count
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [6:0]       hist;
  logic [2:0]       fill;
  logic [RUN_W-1:0] run;
  logic [WIN-2:0]   miss_hist;

  wire rx_bit   = rx_word[0];
  wire pred     = hist[6] ^ hist[5];
  wire miss     = pred != rx_bit;
  wire disagree = (|rx_word) && !(&rx_word);
  wire seeded   = (fill == 3'd7) && (hist != 7'd0);
  wire sat      = &err_count;
  wire drop     = locked && miss && (($countones(miss_hist) + 1) >= DROP_ERRS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist       <= '0;
      fill       <= '0;
      run        <= '0;
      miss_hist  <= '0;
      locked     <= 1'b0;
      line_fault <= 1'b0;
      err_count  <= '0;
    end else if (en) begin
      line_fault <= disagree;
      if (locked) begin
        hist      <= {hist[5:0], pred};
        miss_hist <= {miss_hist[WIN-3:0], miss};
        if (miss && !sat) err_count <= err_count + 1'b1;
        if (drop) begin
          locked <= 1'b0;
          fill   <= '0;
          run    <= '0;
        end
      end else begin
        hist <= {hist[5:0], rx_bit};
        if (fill != 3'd7) fill <= fill + 1'b1;
        if (!seeded || miss) run <= '0;
        else if (run == RUN_W'(LOCK_RUN - 1)) begin
          locked    <= 1'b1;
          run       <= '0;
          miss_hist <= '0;
        end else run <= run + 1'b1;
      end
    end
  end

  // R2
  lock_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> hist != 7'd0);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(locked) && $stable(err_count) && $stable(line_fault));

  // R6
  search_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> $stable(err_count));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));
endmodule

// File: tb/prbs7_align_chk_test.sv
module prbs7_align_chk_test;
  localparam int LINES = 12;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [LINES-1:0] rx_word = '0;
  logic             locked, line_fault;
  logic [CNT_W-1:0] err_count;

  int errors = 0;
  int checks = 0;
  int p = 0;
  logic [126:0] seqb;

  prbs7_align_chk #(.LINES(LINES), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_word(rx_word),
    .locked(locked), .line_fault(line_fault), .err_count(err_count));

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic feed(input logic inv, input logic [LINES-1:0] mask);
    en = 1'b1;
    rx_word = {LINES{seqb[p] ^ inv}} ^ mask;
    p = (p + 1) % 127;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic feed_raw(input logic b);
    en = 1'b1;
    rx_word = {LINES{b}};
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seqb = '0;
    seqb[0] = 1'b1;
    for (int n = 7; n < 127; n++) seqb[n] = seqb[n-7] ^ seqb[n-6];

    @(negedge clk);
    do_reset();
    check("R9 locked", locked, 0);
    check("R9 err_count", err_count, 0);
    check("R9 line_fault", line_fault, 0);

    for (int i = 0; i < 40; i++) feed_raw((i % 4) < 2);
    check("R6 search misses not counted", err_count, 0);
    check("R6 no lock on bad pattern", locked, 0);

    do_reset();
    for (int i = 0; i < 60; i++) feed_raw(1'b0);
    check("R2 zeros never lock", locked, 0);

    for (int ph = 0; ph < 127; ph++) begin
      do_reset();
      p = ph;
      for (int i = 0; i < 22; i++) feed(1'b0, '0);
      check("R1 not locked after 22", locked, 0);
      feed(1'b0, '0);
      check("R1 locked after 23", locked, 1);
      check("R6 no errors during search", err_count, 0);
    end

    en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      rx_word = (i % 2 == 1) ? {LINES{1'b1}} : 12'h5A3;
      @(posedge clk); @(negedge clk);
    end
    check("R8 locked held", locked, 1);
    check("R8 err_count held", err_count, 0);
    check("R8 line_fault held", line_fault, 0);

    feed(1'b0, 12'h008);
    check("R3 line_fault set", line_fault, 1);
    check("R3 line fault not a bit error", err_count, 0);
    feed(1'b0, '0);
    check("R3 line_fault clears", line_fault, 0);

    for (int i = 0; i < 28; i++) feed(i % 4 == 0, '0);
    check("R4 count after 7 errors", err_count, 7);
    check("R4 lock kept with 7 errors", locked, 1);

    for (int i = 0; i < 40; i++) feed(1'b0, '0);
    for (int i = 0; i < 36; i++) feed(i % 5 == 0, '0);
    check("R5 8 errors over 36 samples keep lock", locked, 1);
    check("R4 count after 15 errors", err_count, 15);

    for (int i = 0; i < 40; i++) feed(1'b0, '0);
    for (int i = 0; i < 25; i++) feed(i % 4 == 0, '0);
    check("R5 lock kept at 7th error", locked, 1);
    check("R7 saturated count", err_count, 15);
    for (int i = 0; i < 3; i++) feed(1'b0, '0);
    feed(1'b1, '0);
    check("R5 lock dropped at 8th error", locked, 0);
    check("R7 count stays saturated", err_count, 15);

    for (int i = 0; i < 22; i++) feed(1'b0, '0);
    check("R10 not relocked after 22", locked, 0);
    feed(1'b0, '0);
    check("R10 relocked after 23", locked, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule